// File: doc/BRIEF.md
# Eight-Channel Serial ADC Slave Model

This block stands in for an eight-channel, 12-bit sampling converter on a serial peripheral bus. It lets a bus master be tested without the converter itself. The master sends 16-bit command frames, and each one carries a 3-bit channel number. While the next command is shifting in, the block shifts back the stored sample for the channel named in the previous frame. The reply is therefore always one frame behind the command.

The samples come from an internal bank of eight 12-bit entries. Test logic fills the bank through a synchronous write port. A narrow-resolution input makes the block behave as a 10-bit part. In that mode the two lowest sample bits of every reply are cleared.

The serial clock, chip select and data input are brought into the system clock domain through synchronizers. The system clock must therefore run at least four times faster than the serial clock.

Top module: `adcemu_spi_slave`

## Requirements
- R1: The bus runs in SPI mode 3. The serial clock idles high, data is launched on the falling edge and sampled on the rising edge, and frames are 16 bits long with the most significant bit first.
- R2: The channel number is taken from command bits [13:11]. The other 13 command bits have no effect on any reply.
- R3: Reply bits [15:12] are always zero, and reply bits [11:0] hold the stored sample.
- R4: Each reply carries the sample of the channel named by the command received in the previous frame of the same chip-select window.
- R5: When chip select falls, the pending channel is reset to 0, so the first reply of every window carries channel 0's sample whatever earlier windows sent.
- R6: While narrow_mode is 1, reply bits [1:0] are 0 and reply bits [11:2] equal the stored sample's bits [11:2].
- R7: While chip select is high, spi_miso_oe is 0 and spi_miso is 0. While chip select is low, spi_miso_oe is 1.
- R8: A bank write is visible in every frame whose first falling clock edge comes after the write, and is not visible in a frame that had already begun.
- R9: All eight channels, numbered 0 to 7, can be addressed, each with its own stored sample.
- R10: After reset, every bank entry reads as 0 and the output is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Command data from the master |
| spi_miso | output | 1 | Reply data to the master, 0 while not selected |
| spi_miso_oe | output | 1 | Output enable for the reply line |
| narrow_mode | input | 1 | 1 clears the two lowest reply bits (10-bit behaviour) |
| bank_we | input | 1 | Sample bank write enable |
| bank_waddr | input | 3 | Sample bank entry to write |
| bank_wdata | input | 12 | Sample value to write |

## Verification
A wrong pending channel does not appear on the bus at once. It shows up one frame later, as a reply carrying another channel's sample. If the pending channel is not cleared at window start, the first reply of the window is wrong. A bit counter that slips shifts the whole reply word left or right, so the next complete frame shows nonzero header bits or a corrupted sample. A bank entry loaded at the wrong moment shows only in the frame that straddles the write. For that reason the checks compare every reply word against a model that fixes the expected value at the frame's first falling edge.

// File: rtl/adcemu_pkg.sv
package adcemu_pkg;
  localparam int FRAME_BITS  = 16;
  localparam int SAMPLE_W    = 12;
  localparam int ADDR_W      = 3;
  localparam int ADDR_LSB    = 11;
  localparam int NARROW_DROP = 2;

  typedef logic [ADDR_W-1:0]     chan_t;
  typedef logic [SAMPLE_W-1:0]   sample_t;
  typedef logic [FRAME_BITS-1:0] frame_t;

  // channel field of a received command
  function automatic chan_t cmd_channel(input frame_t cmd);
    return cmd[ADDR_LSB +: ADDR_W];
  endfunction

  // reply word: zero header, sample, optional cleared low bits
  function automatic frame_t reply_frame(input sample_t s, input logic narrow);
    sample_t v;
    v = s;
    if (narrow) v[NARROW_DROP-1:0] = '0;
    return {{(FRAME_BITS-SAMPLE_W){1'b0}}, v};
  endfunction

  // msb-first shift with a new bit at the bottom
  function automatic frame_t shift_in(input frame_t r, input logic b);
    return {r[FRAME_BITS-2:0], b};
  endfunction
endpackage

// File: rtl/adcemu_sync.sv
module adcemu_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL[b]}};
      else        chain <= {chain[STAGES-1:0], d[b]};
    end
    assign q[b]   = chain[STAGES-1];
    assign q_d[b] = chain[STAGES];
  end
endmodule

// File: rtl/adcemu_bank.sv
module adcemu_bank
  import adcemu_pkg::*;
#(
  parameter int CH_NUM = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  chan_t   wr_chan,
  input  sample_t wr_data,
  input  chan_t   rd_chan,
  output sample_t rd_data
);
  sample_t ent [CH_NUM];

  for (genvar gi = 0; gi < CH_NUM; gi++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ent[gi] <= '0;
      else if (wr_en && wr_chan == chan_t'(gi))   ent[gi] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < CH_NUM; i++)
      if (rd_chan == chan_t'(i)) rd_data = ent[i];
  end
endmodule

// File: rtl/adcemu_rx.sv
module adcemu_rx
  import adcemu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   win_start,
  input  logic   rise,
  input  logic   bit_in,
  output chan_t  pend_chan,
  output logic   frame_done,
  output frame_t cmd_word
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS-1);

  logic [CNT_W-1:0] bit_cnt;
  frame_t           shreg;

  assign cmd_word   = shift_in(shreg, bit_in);
  assign frame_done = rise && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      pend_chan <= '0;
    end else if (win_start) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      pend_chan <= '0;
    end else if (rise) begin
      shreg   <= cmd_word;
      bit_cnt <= frame_done ? '0 : bit_cnt + 1'b1;
      if (frame_done) pend_chan <= cmd_channel(cmd_word);
    end
  end
endmodule

// File: rtl/adcemu_tx.sv
module adcemu_tx
  import adcemu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   idle,
  input  logic   win_start,
  input  logic   fall,
  input  frame_t reply,
  output logic   miso,
  output logic   miso_oe,
  output logic   frame_start
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS-1);

  logic [CNT_W-1:0] fall_cnt;
  frame_t           tx_sh;

  assign frame_start = fall && (fall_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt <= '0;
      tx_sh    <= '0;
      miso     <= 1'b0;
      miso_oe  <= 1'b0;
    end else begin
      miso_oe <= !idle;
      if (idle) begin
        miso     <= 1'b0;
        fall_cnt <= '0;
      end else if (win_start) begin
        fall_cnt <= '0;
      end else if (fall) begin
        fall_cnt <= (fall_cnt == LAST) ? '0 : fall_cnt + 1'b1;
        if (frame_start) begin
          miso  <= reply[FRAME_BITS-1];
          tx_sh <= shift_in(reply, 1'b0);
        end else begin
          miso  <= tx_sh[FRAME_BITS-1];
          tx_sh <= shift_in(tx_sh, 1'b0);
        end
      end
    end
  end
endmodule

// File: rtl/adcemu_spi_slave.sv
module adcemu_spi_slave
  import adcemu_pkg::*;
#(
  parameter int CH_NUM      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sck,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                spi_miso_oe,
  input  logic                narrow_mode,
  input  logic                bank_we,
  input  logic [ADDR_W-1:0]   bank_waddr,
  input  logic [SAMPLE_W-1:0] bank_wdata
);
  // synchronized bus pins: {cs, sck, mosi}
  logic [2:0] pin_s, pin_d;
  logic cs_s, cs_d, sck_s, sck_d, mosi_s;

  adcemu_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_mosi}),
    .q(pin_s), .q_d(pin_d)
  );

  assign cs_s   = pin_s[2];
  assign cs_d   = pin_d[2];
  assign sck_s  = pin_s[1];
  assign sck_d  = pin_d[1];
  assign mosi_s = pin_s[0];

  // named internal events
  logic cs_fall, sck_rise, sck_fall;
  assign cs_fall  = !cs_s && cs_d;
  assign sck_rise = !cs_s &&  sck_s && !sck_d;
  assign sck_fall = !cs_s && !sck_s &&  sck_d;

  chan_t   pend_chan;
  logic    frame_done, frame_start;
  frame_t  cmd_word, reply_word;
  sample_t bank_rd;

  adcemu_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .win_start(cs_fall), .rise(sck_rise), .bit_in(mosi_s),
    .pend_chan(pend_chan), .frame_done(frame_done), .cmd_word(cmd_word)
  );

  adcemu_bank #(.CH_NUM(CH_NUM)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bank_we), .wr_chan(bank_waddr), .wr_data(bank_wdata),
    .rd_chan(pend_chan), .rd_data(bank_rd)
  );

  assign reply_word = reply_frame(bank_rd, narrow_mode);

  adcemu_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .idle(cs_s), .win_start(cs_fall), .fall(sck_fall),
    .reply(reply_word),
    .miso(spi_miso), .miso_oe(spi_miso_oe), .frame_start(frame_start)
  );
endmodule

// File: rtl/adcemu_spi_slave_chk.sv
module adcemu_spi_slave_chk
  import adcemu_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cs_idle,
  input logic   cs_fall,
  input logic   frame_start,
  input logic   frame_done,
  input frame_t cmd_word,
  input chan_t  pend_chan,
  input frame_t reply_word,
  input logic   narrow_mode,
  input logic   miso,
  input logic   miso_oe
);
  AST_IDLE_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (!miso_oe && !miso)); // R7
  AST_ACTIVE_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_idle |=> miso_oe); // R7
  AST_WINDOW_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (pend_chan == '0)); // R5
  AST_ADDR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cs_fall) |=> (pend_chan == $past(cmd_word[ADDR_LSB +: ADDR_W]))); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !cs_fall) |=> $stable(pend_chan)); // R4
  AST_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !cs_idle) |=> !miso); // R3
  AST_NARROW_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_mode |-> (reply_word[NARROW_DROP-1:0] == '0)); // R6
endmodule

bind adcemu_spi_slave adcemu_spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cs_idle(cs_s), .cs_fall(cs_fall),
  .frame_start(frame_start), .frame_done(frame_done),
  .cmd_word(cmd_word), .pend_chan(pend_chan),
  .reply_word(reply_word), .narrow_mode(narrow_mode),
  .miso(spi_miso), .miso_oe(spi_miso_oe)
);

// File: tb/adcemu_spi_slave_test.sv
`timescale 1ns/1ps
module adcemu_spi_slave_test;
  logic clk = 0;
  logic rst_n = 0;
  logic spi_sck = 1, spi_cs_n = 1, spi_mosi = 0;
  logic spi_miso, spi_miso_oe;
  logic narrow_mode = 0;
  logic bank_we = 0;
  logic [2:0]  bank_waddr = 0;
  logic [11:0] bank_wdata = 0;

  always #10 clk = ~clk;

  adcemu_spi_slave uut (
    .clk(clk), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .narrow_mode(narrow_mode),
    .bank_we(bank_we), .bank_waddr(bank_waddr), .bank_wdata(bank_wdata)
  );

  int total = 0, bad = 0;
  int model_bank [8];
  int model_pend = 0;
  int frame_no = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_reply(input int v);
    return narrow_mode ? (v & 'h0FFC) : (v & 'h0FFF);
  endfunction

  // per-clock line monitor (R7)
  int hi_run = 0, lo_run = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      hi_run = 0; lo_run = 0;
    end else begin
      if (spi_cs_n) begin hi_run++; lo_run = 0; end
      else          begin lo_run++; hi_run = 0; end
      if (hi_run >= 4) check("R7 idle", {30'd0, spi_miso_oe, spi_miso}, 0);
      if (lo_run >= 4) check("R7 active", {31'd0, spi_miso_oe}, 1);
    end
  end

  task automatic bank_write(input int ch, input int val);
    bank_we = 1; bank_waddr = 3'(ch); bank_wdata = 12'(val);
    @(negedge clk);
    bank_we = 0;
    model_bank[ch] = val & 'hFFF;
  endtask

  task automatic open_win();
    spi_cs_n = 0;
    repeat (5) @(negedge clk);
    model_pend = 0;
  endtask

  task automatic close_win();
    repeat (4) @(negedge clk);
    spi_cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  // one mode-3 frame; junk fills the non-address command bits
  task automatic xfer(input int ch, input string tag,
                      input bit mid_wr = 0, input int wch = 0, input int wval = 0);
    logic [15:0] cmd, rsp, junk;
    int exp;
    frame_no++;
    junk = 16'(frame_no * 'h9E37);
    cmd  = {junk[15:14], 3'(ch), junk[10:0]};
    exp  = exp_reply(model_bank[model_pend]);
    for (int i = 15; i >= 0; i--) begin
      spi_sck = 0; spi_mosi = cmd[i];
      repeat (8) @(negedge clk);
      if (mid_wr && i == 8) bank_write(wch, wval);
      rsp[i] = spi_miso;
      spi_sck = 1;
      repeat (8) @(negedge clk);
    end
    check(tag, {16'd0, rsp}, exp);
    model_pend = ch;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model_bank[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset oe", {31'd0, spi_miso_oe}, 0);
    check("R10 reset miso", {31'd0, spi_miso}, 0);

    // empty bank replies zero
    open_win();
    xfer(5, "R10");
    xfer(2, "R10");
    xfer(7, "R10");
    close_win();

    for (int i = 0; i < 8; i++) bank_write(i, i * 'h2B5 + 'h137);

    // pipelined replies across all channels
    open_win();
    xfer(7, "R5 first");
    xfer(0, "R4");
    xfer(3, "R9");
    xfer(3, "R4");
    xfer(1, "R4");
    xfer(6, "R2");
    xfer(2, "R9");
    xfer(4, "R1");
    xfer(5, "R9");
    xfer(0, "R9");
    xfer(1, "R9");
    close_win();

    // pending channel does not survive a window
    open_win();
    xfer(4, "R5");
    xfer(4, "R4");
    close_win();
    open_win();
    xfer(2, "R5");
    close_win();

    // 10-bit behaviour
    narrow_mode = 1;
    open_win();
    for (int c = 0; c < 8; c++) xfer(c, "R6");
    xfer(0, "R6");
    close_win();
    narrow_mode = 0;

    // write timing
    open_win();
    xfer(3, "R8");
    xfer(3, "R8 frame in flight", 1, 3, 'hABC);
    xfer(0, "R8 next frame");
    bank_write(0, 'h5A5);
    xfer(6, "R8 between frames");
    bank_write(6, 'hFFF);
    xfer(2, "R3 full scale");
    xfer(2, "R3");
    close_win();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule